// File: doc/BRIEF.md
# Register-Amount Shift Execution Unit

This block executes the six shift operations of an integer pipeline that take their shift amount from a register: logical left, logical right and arithmetic right, each in a 32-bit word form and a 64-bit doubleword form. The pipeline supplies the source operand, the value of the amount register, the low eleven bits of the instruction word and a summary-overflow flag. One cycle later the unit presents a registered result and a valid strobe.

The amount is taken with one bit more than the operand width needs. An amount that reaches or passes the operand width does not wrap. A logical shift then gives zero, and an arithmetic shift gives a full copy of the sign bit. When the instruction's record bit is set, the unit also loads a 4-bit condition field. This field holds the result of a signed compare of the 64-bit result against zero, plus the overflow flag. When the record bit is clear, the field keeps its previous value.

Top module: `shift_exec_unit`

## Requirements
- R1: A word operation takes its amount from amtVal[5:0] and a doubleword operation from amtVal[6:0]. All higher bits of amtVal have no effect on the result.
- R2: A logical left or right word shift with an amount from 32 to 63 gives a result of zero.
- R3: An arithmetic right word shift with an amount of 31 or less shifts srcVal[31:0] right with sign fill. Its 64-bit result is sign-extended from bit 31. With an amount of 32 to 63 the result is 64 copies of srcVal[31].
- R4: A doubleword logical shift with an amount from 64 to 127 gives zero. A doubleword arithmetic right shift in that range gives 64 copies of srcVal[63].
- R5: A logical right word shift reads only srcVal[31:0]. Both logical word shifts return zero in result[63:32].
- R6: The operation is decoded from instrLow[10:1]: 24 is left word, 536 is logical right word, 792 is arithmetic right word, 27 is left doubleword, 539 is logical right doubleword, 794 is arithmetic right doubleword.
- R7: When instrLow[0] is 1 and the code is known, crField loads {LT, GT, EQ, SO}. LT is in bit 3 and SO in bit 0. LT, GT and EQ come from a signed compare of the 64-bit result with zero, so exactly one of them is set. SO is a copy of soIn.
- R8: When instrLow[0] is 0, crField keeps its value.
- R9: result and outValid are registered. outValid is 1 in the cycle after an inValid cycle and 0 otherwise. result holds its value while inValid is 0.
- R10: During and after reset, outValid, result and crField are 0.
- R11: An unknown code gives a result of zero and leaves crField unchanged, even with the record bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation strobe |
| instrLow | input | 11 | Instruction bits 10:0; bits 10:1 select the operation, bit 0 is the record bit |
| srcVal | input | 64 | Source operand |
| amtVal | input | 64 | Shift-amount register value |
| soIn | input | 1 | Summary-overflow flag copied into the condition field |
| outValid | output | 1 | Result valid |
| result | output | 64 | Registered shift result |
| crField | output | 4 | Condition field {LT, GT, EQ, SO} |

## Verification
The unit has a single register stage, so a wrong amount decode or fill choice shows up in result in the cycle right after the strobe. The amount sweep runs each operation at zero, at width minus one, at the width, just past it and at the top masked value. It uses sources of both signs, so a wrapped amount or a lost sign shows at once. The condition field is state, and a wrong update survives until the next recorded operation. For that reason the field is compared after every operation, including the ones that must leave it alone.

// File: rtl/shift_unit_pkg.sv
package shift_unit_pkg;

  typedef enum logic [9:0] {
    XO_SLW  = 10'd24,
    XO_SRW  = 10'd536,
    XO_SRAW = 10'd792,
    XO_SLD  = 10'd27,
    XO_SRD  = 10'd539,
    XO_SRAD = 10'd794
  } xo_code_e;

  typedef struct packed {
    logic isWord;
    logic isLeft;
    logic isArith;
    logic opKnown;
    logic loadRes;
    logic loadCond;
  } shift_strobes_t;

endpackage

// File: rtl/shift_unit_ctrl.sv
module shift_unit_ctrl
  import shift_unit_pkg::*;
(
  input  logic           inValid,
  input  logic [10:0]    instrLow,
  output shift_strobes_t strobes
);

  logic recordBit;
  assign recordBit = instrLow[0];

  always_comb begin
    strobes = '0;
    strobes.opKnown = 1'b1;
    case (instrLow[10:1])
      XO_SLW:  begin strobes.isWord = 1'b1; strobes.isLeft = 1'b1; end
      XO_SRW:  begin strobes.isWord = 1'b1; end
      XO_SRAW: begin strobes.isWord = 1'b1; strobes.isArith = 1'b1; end
      XO_SLD:  begin strobes.isLeft = 1'b1; end
      XO_SRD:  begin end
      XO_SRAD: begin strobes.isArith = 1'b1; end
      default: strobes.opKnown = 1'b0;
    endcase
    strobes.loadRes  = inValid;
    strobes.loadCond = inValid & recordBit & strobes.opKnown;
  end

endmodule

// File: rtl/shift_unit_datapath.sv
module shift_unit_datapath
  import shift_unit_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  shift_strobes_t              strobes,
  input  logic [XLEN-1:0]             srcVal,
  input  logic [$clog2(XLEN):0]       amtLow,
  input  logic                        soIn,
  output logic                        outValid,
  output logic [XLEN-1:0]             result,
  output logic [3:0]                  crField
);

  localparam int unsigned WLEN  = XLEN / 2;
  localparam int unsigned SH_W  = $clog2(XLEN);
  localparam int unsigned AMT_W = SH_W + 1;

  logic [AMT_W-1:0]       amtEff;
  logic                   overRange;
  logic [SH_W-1:0]        shAmt;
  logic [XLEN-1:0]        opnd;
  logic signed [XLEN-1:0] opndS;
  logic [XLEN-1:0]        leftRaw;
  logic [XLEN-1:0]        leftRes;
  logic [XLEN-1:0]        rightRes;
  logic [XLEN-1:0]        fillVal;
  logic [XLEN-1:0]        nextRes;
  logic                   ltN;
  logic                   eqN;
  logic                   gtN;

  // amount: word form drops the top bit, the top remaining bit flags over-range
  always_comb begin
    amtEff    = strobes.isWord ? {1'b0, amtLow[SH_W-1:0]} : amtLow;
    overRange = strobes.isWord ? amtEff[SH_W-1] : amtEff[AMT_W-1];
    shAmt     = amtEff[SH_W-1:0];
  end

  // widen the word operand so one full-width shifter serves all forms
  always_comb begin
    if (!strobes.isWord)
      opnd = srcVal;
    else if (strobes.isArith)
      opnd = {{WLEN{srcVal[WLEN-1]}}, srcVal[WLEN-1:0]};
    else
      opnd = {{WLEN{1'b0}}, srcVal[WLEN-1:0]};
  end

  assign opndS = opnd;

  always_comb begin
    leftRaw  = opnd << shAmt;
    leftRes  = strobes.isWord ? {{WLEN{1'b0}}, leftRaw[WLEN-1:0]} : leftRaw;
    rightRes = strobes.isArith ? XLEN'(opndS >>> shAmt) : (opnd >> shAmt);
    fillVal  = strobes.isArith ? {XLEN{opnd[XLEN-1]}} : '0;
    if (!strobes.opKnown)
      nextRes = '0;
    else if (overRange)
      nextRes = fillVal;
    else if (strobes.isLeft)
      nextRes = leftRes;
    else
      nextRes = rightRes;
  end

  always_comb begin
    ltN = nextRes[XLEN-1];
    eqN = (nextRes == '0);
    gtN = !ltN && !eqN;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      result   <= '0;
      crField  <= '0;
    end else begin
      outValid <= strobes.loadRes;
      if (strobes.loadRes)
        result <= nextRes;
      if (strobes.loadCond)
        crField <= {ltN, gtN, eqN, soIn};
    end
  end

endmodule

// File: rtl/shift_exec_unit.sv
module shift_exec_unit
  import shift_unit_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [10:0]     instrLow,
  input  logic [XLEN-1:0] srcVal,
  input  logic [XLEN-1:0] amtVal,
  input  logic            soIn,
  output logic            outValid,
  output logic [XLEN-1:0] result,
  output logic [3:0]      crField
);

  localparam int unsigned AMT_W = $clog2(XLEN) + 1;

  shift_strobes_t strobes;

  shift_unit_ctrl u_ctrl (
    .inValid (inValid),
    .instrLow(instrLow),
    .strobes (strobes)
  );

  shift_unit_datapath #(.XLEN(XLEN)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .srcVal  (srcVal),
    .amtLow  (amtVal[AMT_W-1:0]),
    .soIn    (soIn),
    .outValid(outValid),
    .result  (result),
    .crField (crField)
  );

endmodule

// File: rtl/shift_exec_unit_chk.sv
module shift_exec_unit_chk
  import shift_unit_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input logic            clk,
  input logic            rstN,
  input logic            inValid,
  input logic [10:0]     instrLow,
  input logic [XLEN-1:0] srcVal,
  input logic [XLEN-1:0] amtVal,
  input logic            soIn,
  input logic            outValid,
  input logic [XLEN-1:0] result,
  input logic [3:0]      crField
);

  localparam int unsigned WLEN  = XLEN / 2;
  localparam int unsigned AMT_W = $clog2(XLEN) + 1;
  localparam logic [XLEN-1:0] DW_MASK = XLEN'((1 << AMT_W) - 1);

  logic isKnown;
  assign isKnown = (instrLow[10:1] == XO_SLW)  || (instrLow[10:1] == XO_SRW) ||
                   (instrLow[10:1] == XO_SRAW) || (instrLow[10:1] == XO_SLD) ||
                   (instrLow[10:1] == XO_SRD)  || (instrLow[10:1] == XO_SRAD);

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  a_r9_valid_drops: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid && $stable(result));

  a_r8_cond_held: assert property (@(posedge clk) disable iff (!rstN)
    !(inValid && instrLow[0] && isKnown) |=> $stable(crField));

  a_r7_one_relation: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && instrLow[0] && isKnown) |=>
      ($countones(crField[3:1]) == 1) && (crField[3] == result[XLEN-1]) &&
      (crField[0] == $past(soIn)));

  a_r3_sraw_fill: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && instrLow[10:1] == XO_SRAW && amtVal[AMT_W-2]) |=>
      result == {XLEN{$past(srcVal[WLEN-1])}});

  a_r4_sld_zero: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && instrLow[10:1] == XO_SLD && (amtVal & DW_MASK) >= XLEN) |=>
      result == '0);

  a_r1_srd_zero_amount: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && instrLow[10:1] == XO_SRD && (amtVal & DW_MASK) == '0) |=>
      result == $past(srcVal));

  a_r11_unknown_zero: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !isKnown) |=> result == '0);

endmodule

bind shift_exec_unit shift_exec_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .instrLow(instrLow),
  .srcVal  (srcVal),
  .amtVal  (amtVal),
  .soIn    (soIn),
  .outValid(outValid),
  .result  (result),
  .crField (crField)
);

// File: tb/tb_shift_exec_unit.sv
module tb_shift_exec_unit;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 9;
  localparam logic [9:0] C_SLW = 10'd24, C_SRW = 10'd536, C_SRAW = 10'd792;
  localparam logic [9:0] C_SLD = 10'd27, C_SRD = 10'd539, C_SRAD = 10'd794;

  // {code, src, amount, expected}
  localparam logic [201:0] VEC [NVEC] = '{
    {C_SRW,  64'hFFFF_FFFF_8000_0000, 64'd4,   64'h0000_0000_0800_0000},
    {C_SLW,  64'h0000_0000_0000_0001, 64'h5F,  64'h0000_0000_8000_0000},
    {C_SRAW, 64'h0000_0000_8000_0000, 64'd1,   64'hFFFF_FFFF_C000_0000},
    {C_SRAW, 64'h0000_0000_7FFF_FFFF, 64'd40,  64'h0000_0000_0000_0000},
    {C_SRD,  64'h8000_0000_0000_0000, 64'hBF,  64'h0000_0000_0000_0001},
    {C_SLD,  64'h0000_0000_0000_0001, 64'd64,  64'h0000_0000_0000_0000},
    {C_SRAD, 64'h8000_0000_0000_0000, 64'd127, 64'hFFFF_FFFF_FFFF_FFFF},
    {C_SLD,  64'h0000_0000_0000_00FF, 64'h100, 64'h0000_0000_0000_00FF},
    {C_SRAW, 64'hFFFF_FFFF_0000_0010, 64'd2,   64'h0000_0000_0000_0004}
  };
  localparam logic [9:0] OPS [6] = '{C_SLW, C_SRW, C_SRAW, C_SLD, C_SRD, C_SRAD};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [10:0] instrLow = '0;
  logic [63:0] srcVal = '0;
  logic [63:0] amtVal = '0;
  logic        soIn = 1'b0;
  logic        outValid;
  logic [63:0] result;
  logic [3:0]  crField;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [3:0]  expCr = '0;
  logic [63:0] lastRes;

  always #(CLK_PERIOD/2) clk = ~clk;

  shift_exec_unit dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .instrLow(instrLow),
    .srcVal(srcVal), .amtVal(amtVal), .soIn(soIn),
    .outValid(outValid), .result(result), .crField(crField)
  );

  function automatic logic [63:0] model(input logic [9:0] xo, input logic [63:0] s,
                                        input logic [63:0] a);
    int unsigned n;
    logic [31:0] w;
    logic signed [63:0] t;
    model = '0;
    case (xo)
      C_SLW:  begin n = a[5:0]; w = s[31:0] << n; model = (n > 31) ? 64'd0 : {32'd0, w}; end
      C_SRW:  begin n = a[5:0]; w = s[31:0] >> n; model = (n > 31) ? 64'd0 : {32'd0, w}; end
      C_SRAW: begin
        n = a[5:0]; t = {{32{s[31]}}, s[31:0]};
        model = (n > 31) ? {64{s[31]}} : 64'(t >>> n);
      end
      C_SLD:  begin n = a[6:0]; model = (n > 63) ? 64'd0 : (s << n); end
      C_SRD:  begin n = a[6:0]; model = (n > 63) ? 64'd0 : (s >> n); end
      C_SRAD: begin
        n = a[6:0]; t = s;
        model = (n > 63) ? {64{s[63]}} : 64'(t >>> n);
      end
      default: model = '0;
    endcase
  endfunction

  function automatic bit knownCode(input logic [9:0] xo);
    return (xo == C_SLW) || (xo == C_SRW) || (xo == C_SRAW) ||
           (xo == C_SLD) || (xo == C_SRD) || (xo == C_SRAD);
  endfunction

  function automatic logic [3:0] condOf(input logic [63:0] r, input logic so);
    return {r[63], !r[63] && (r != 0), r == 0, so};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic runOp(input logic [9:0] xo, input logic rec, input logic [63:0] s,
                       input logic [63:0] a, input logic so);
    @(negedge clk);
    inValid = 1'b1; instrLow = {xo, rec}; srcVal = s; amtVal = a; soIn = so;
    if (rec && knownCode(xo)) expCr = condOf(model(xo, s, a), so);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset values
    check("R10 outValid", 64'(outValid), 64'd0);
    check("R10 result", result, 64'd0);
    check("R10 crField", 64'(crField), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R10 after release", 64'(outValid), 64'd0);

    // table vectors: R1 R2 R3 R4 R5 R6
    for (int i = 0; i < NVEC; i++) begin
      runOp(VEC[i][201:192], 1'b1, VEC[i][191:128], VEC[i][127:64], 1'b0);
      check("R1/R3/R4/R5/R6 table", result, VEC[i][63:0]);
      check("R7 table cr", 64'(crField), 64'(expCr));
    end

    // amount sweep for every operation with both source signs (R2 R3 R4 R5)
    for (int o = 0; o < 6; o++) begin
      for (int sg = 0; sg < 2; sg++) begin
        for (int k = 0; k < 5; k++) begin
          int unsigned wd;
          logic [63:0] src;
          logic [63:0] amt;
          wd = (o < 3) ? 32 : 64;
          src = sg ? 64'h8765_4321_8765_4321 : 64'h1234_5678_1234_5679;
          case (k)
            0: amt = 64'd0;
            1: amt = 64'(wd - 1);
            2: amt = 64'(wd);
            3: amt = 64'(wd + 1);
            default: amt = 64'(2 * wd - 1);
          endcase
          runOp(OPS[o], 1'b1, src, amt, k[0]);
          check("R2/R3/R4 sweep", result, model(OPS[o], src, amt));
          check("R7 sweep cr", 64'(crField), 64'(expCr));
        end
      end
    end

    // R9: valid one cycle, result held while idle
    runOp(C_SRD, 1'b1, 64'hF0, 64'd4, 1'b0);
    check("R9 outValid high", 64'(outValid), 64'd1);
    lastRes = result;
    @(negedge clk);
    check("R9 outValid low", 64'(outValid), 64'd0);
    check("R9 result held", result, lastRes);

    // R7: SO copied, zero result gives EQ
    runOp(C_SLW, 1'b1, 64'h1, 64'd32, 1'b1);
    check("R7 zero with so", 64'(crField), 64'h3);
    // R7: negative result gives LT
    runOp(C_SRAD, 1'b1, 64'h8000_0000_0000_0000, 64'd3, 1'b0);
    check("R7 negative", 64'(crField), 64'h8);

    // R8: record bit clear leaves crField
    runOp(C_SRW, 1'b0, 64'h10, 64'd1, 1'b1);
    check("R8 result", result, 64'h8);
    check("R8 crField kept", 64'(crField), 64'h8);

    // R11: unknown code, record bit set
    runOp(10'd100, 1'b1, 64'hFFFF, 64'd1, 1'b1);
    check("R11 result zero", result, 64'd0);
    check("R11 crField kept", 64'(crField), 64'h8);

    // R1: upper amount bits ignored for a word shift
    runOp(C_SRW, 1'b1, 64'h0000_0000_0000_0100, 64'hFFFF_FF00_0000_0004, 1'b0);
    check("R1 high amount bits", result, 64'h10);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule